// File: doc/BRIEF.md
# Paired-Channel PWM Generator

This block produces one pulse-width-modulated output per channel. Channels come in pairs, and the two channels of a pair share one clock configuration. That configuration picks one of two clock-enable pulse inputs and divides the pulse train by a power of two. Each channel then divides the result again with its own 8-bit prescaler, counts ticks across a programmable period, and drives its active level for a programmable number of ticks at the start of each period. Each channel also has an output-enable, so a disabled channel can be tri-stated by the pad logic.

Software sets the block up through a simple synchronous register bus. Reads have one cycle of latency. New timing values take effect at once: the period in progress is dropped and the channel starts a fresh period on the next cycle. The two clock sources are modelled as single-cycle enable pulses (`oscPulse`, `busPulse`) in the core clock domain, so the block has no real clock multiplexer.

Top module: `pair_pwm`

## Requirements
- R1: While reset is asserted, and right after it is released, every `pwmOe` and `pwmOut` bit is 0 and `rdData` is 0.
- R2: Register map. Pair clock config p is at 0x020+4p, with the source in bits [8:7] and the divider exponent M in bits [3:0]. The gate register is at 0x040, with the per-channel count gate in bits [NUM_CH-1:0] and the per-channel bypass at bit 16+ch. The enable register is at 0x080, with bit ch for channel ch. Channel ch control is at 0x100+0x20*ch, with the prescaler K in bits [7:0] and the polarity in bit 8. Channel ch timing is at 0x104+0x20*ch, with the last tick index ENTIRE in bits [31:16] and the active length ACT in bits [15:0]. A read returns the value on `rdData` in the cycle after `rdEn`. Bits with no field, unmapped addresses, and cycles with no read all return 0.
- R3: A pair source value of 0 selects `oscPulse`; any nonzero value selects `busPulse`. The selected pulses are divided by 2^M, and both channels of the pair use the result.
- R4: A channel advances one tick for every K+1 divided pulses.
- R5: A period lasts ENTIRE+1 ticks. The output is at the active level for the first ACT ticks and at the inactive level for the rest. Polarity 1 means the active level is high; polarity 0 means it is low.
- R6: If ACT > ENTIRE the output holds the active level all the time. If ACT = 0 it holds the inactive level.
- R7: A channel whose enable bit is 0 drives `pwmOe` = 0 and `pwmOut` = 0 in the cycle after the write, and its counters are cleared. When it is enabled again, it starts a new period in the active phase.
- R8: An enabled channel whose gate bit is 0 stops counting and holds its output. With its bypass bit set, a channel advances one tick per selected source pulse, ignoring M and K.
- R9: A write to a channel's control or timing register restarts that channel at tick 0 of a new period on the next cycle. A write to a pair config register restarts that pair's divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscPulse | input | 1 | Clock-enable pulse of the oscillator source |
| busPulse | input | 1 | Clock-enable pulse of the bus source |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 12 | Register byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after `rdEn` |
| pwmOut | output | NUM_CH | PWM output per channel |
| pwmOe | output | NUM_CH | Output enable per channel |

## Verification
A write to a channel's timing register can arrive in the same cycle as a prescaled tick or a period wrap on that channel, and the restart must take precedence over the advance. The bench drives several writes while the dividers are running, with the bus source pulsing every third cycle, so some writes land on tick cycles. A behavioural reference model, updated on every clock, judges the outputs cycle by cycle, and a directed check confirms that a channel written during its inactive phase re-enters the active phase one cycle later.

// File: rtl/pwmp_pkg.sv
package pwmp_pkg;
  parameter int unsigned NUM_CH = 4;
  localparam int unsigned NUM_PAIR = NUM_CH / 2;
  localparam int unsigned PRE_W = 8;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned SRC_W = 2;
  localparam int unsigned DIVEXP_W = 4;
  localparam int unsigned DIV_W = (1 << DIVEXP_W) - 1;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam bit [ADDR_W-1:0] CFG_BASE  = 12'h020;
  localparam bit [ADDR_W-1:0] GATE_ADDR = 12'h040;
  localparam bit [ADDR_W-1:0] EN_ADDR   = 12'h080;
  localparam bit [ADDR_W-1:0] CH_BASE   = 12'h100;
  localparam int unsigned CFG_STRIDE = 4;
  localparam int unsigned CH_STRIDE  = 32;
  localparam int unsigned TIME_OFS   = 4;

  localparam int unsigned SRC_LSB    = 7;
  localparam int unsigned POL_BIT    = 8;
  localparam int unsigned ENTIRE_LSB = 16;
  localparam int unsigned BYPASS_LSB = 16;

  typedef struct packed {
    logic [SRC_W-1:0]    src;
    logic [DIVEXP_W-1:0] divExp;
  } pairCfg_t;

  typedef struct packed {
    logic             en;
    logic             gate;
    logic             bypass;
    logic             pol;
    logic [PRE_W-1:0] presc;
    logic [CNT_W-1:0] entire;
    logic [CNT_W-1:0] act;
  } chCfg_t;

  typedef struct packed {
    logic [NUM_CH-1:0]   chRestart;
    logic [NUM_PAIR-1:0] pairRestart;
  } strobe_t;
endpackage

// File: rtl/pwmp_ctrl.sv
module pwmp_ctrl
  import pwmp_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  output pairCfg_t [NUM_PAIR-1:0]        pairCfg,
  output chCfg_t   [NUM_CH-1:0]          chCfg,
  output strobe_t                        strobes
);
  logic [NUM_PAIR-1:0][SRC_W-1:0]    srcReg;
  logic [NUM_PAIR-1:0][DIVEXP_W-1:0] divExpReg;
  logic [NUM_CH-1:0][PRE_W-1:0]      prescReg;
  logic [NUM_CH-1:0]                 polReg;
  logic [NUM_CH-1:0][CNT_W-1:0]      entireReg;
  logic [NUM_CH-1:0][CNT_W-1:0]      actReg;
  logic [NUM_CH-1:0]                 enReg, gateReg, bypassReg;

  logic [NUM_PAIR-1:0] cfgHit;
  logic [NUM_CH-1:0]   ctlHit, timeHit;
  logic                gateHit, enHit;
  logic [DATA_W-1:0]   rdNext;

  // address decode
  always_comb begin
    for (int p = 0; p < NUM_PAIR; p++)
      cfgHit[p] = (addr == CFG_BASE + ADDR_W'(p * CFG_STRIDE));
    for (int c = 0; c < NUM_CH; c++) begin
      ctlHit[c]  = (addr == CH_BASE + ADDR_W'(c * CH_STRIDE));
      timeHit[c] = (addr == CH_BASE + ADDR_W'(c * CH_STRIDE + TIME_OFS));
    end
    gateHit = (addr == GATE_ADDR);
    enHit   = (addr == EN_ADDR);
  end

  // restart strobes towards the datapath
  always_comb begin
    strobes = '0;
    for (int c = 0; c < NUM_CH; c++)
      strobes.chRestart[c] = wrEn && (ctlHit[c] || timeHit[c]);
    for (int p = 0; p < NUM_PAIR; p++)
      strobes.pairRestart[p] = wrEn && cfgHit[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg    <= '0;
      divExpReg <= '0;
      prescReg  <= '0;
      polReg    <= '0;
      entireReg <= '0;
      actReg    <= '0;
      enReg     <= '0;
      gateReg   <= '0;
      bypassReg <= '0;
    end else if (wrEn) begin
      for (int p = 0; p < NUM_PAIR; p++) begin
        if (cfgHit[p]) begin
          srcReg[p]    <= wrData[SRC_LSB +: SRC_W];
          divExpReg[p] <= wrData[DIVEXP_W-1:0];
        end
      end
      for (int c = 0; c < NUM_CH; c++) begin
        if (ctlHit[c]) begin
          prescReg[c] <= wrData[PRE_W-1:0];
          polReg[c]   <= wrData[POL_BIT];
        end
        if (timeHit[c]) begin
          entireReg[c] <= wrData[ENTIRE_LSB +: CNT_W];
          actReg[c]    <= wrData[CNT_W-1:0];
        end
      end
      if (gateHit) begin
        gateReg   <= wrData[NUM_CH-1:0];
        bypassReg <= wrData[BYPASS_LSB +: NUM_CH];
      end
      if (enHit) enReg <= wrData[NUM_CH-1:0];
    end
  end

  // read mux, unassigned bits stay zero
  always_comb begin
    rdNext = '0;
    for (int p = 0; p < NUM_PAIR; p++) begin
      if (cfgHit[p]) begin
        rdNext[SRC_LSB +: SRC_W]  = srcReg[p];
        rdNext[DIVEXP_W-1:0]      = divExpReg[p];
      end
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (ctlHit[c]) begin
        rdNext[PRE_W-1:0] = prescReg[c];
        rdNext[POL_BIT]   = polReg[c];
      end
      if (timeHit[c]) begin
        rdNext[ENTIRE_LSB +: CNT_W] = entireReg[c];
        rdNext[CNT_W-1:0]           = actReg[c];
      end
    end
    if (gateHit) begin
      rdNext[NUM_CH-1:0]            = gateReg;
      rdNext[BYPASS_LSB +: NUM_CH]  = bypassReg;
    end
    if (enHit) rdNext[NUM_CH-1:0] = enReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdEn ? rdNext : '0;
  end

  always_comb begin
    for (int p = 0; p < NUM_PAIR; p++) begin
      pairCfg[p].src    = srcReg[p];
      pairCfg[p].divExp = divExpReg[p];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      chCfg[c].en     = enReg[c];
      chCfg[c].gate   = gateReg[c];
      chCfg[c].bypass = bypassReg[c];
      chCfg[c].pol    = polReg[c];
      chCfg[c].presc  = prescReg[c];
      chCfg[c].entire = entireReg[c];
      chCfg[c].act    = actReg[c];
    end
  end
endmodule

// File: rtl/pwmp_chan.sv
module pwmp_chan
  import pwmp_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   srcTick,
  input  logic   divTick,
  input  logic   restart,
  input  chCfg_t cfg,
  output logic   pwmOut,
  output logic   pwmOe
);
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] tickCnt;
  logic             baseTick, stepTick, activePhase;

  assign baseTick = cfg.bypass ? srcTick : divTick;
  assign stepTick = baseTick && (cfg.bypass || preCnt == cfg.presc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (restart || !cfg.en) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (cfg.gate && baseTick) begin
      if (stepTick) begin
        preCnt  <= '0;
        tickCnt <= (tickCnt >= cfg.entire) ? '0 : tickCnt + CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  assign activePhase = (tickCnt < cfg.act);
  assign pwmOut = cfg.en && (activePhase ? cfg.pol : !cfg.pol);
  assign pwmOe  = cfg.en;
endmodule

// File: rtl/pwmp_datapath.sv
module pwmp_datapath
  import pwmp_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    oscPulse,
  input  logic                    busPulse,
  input  pairCfg_t [NUM_PAIR-1:0] pairCfg,
  input  chCfg_t   [NUM_CH-1:0]   chCfg,
  input  strobe_t                 strobes,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic [NUM_CH-1:0]       pwmOe
);
  logic [NUM_PAIR-1:0] srcTick, divTick;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    logic [DIV_W-1:0] divCnt, limit;

    // limit = 2^M - 1 as a thermometer code
    for (genvar b = 0; b < DIV_W; b++) begin : g_lim
      assign limit[b] = (DIVEXP_W'(b) < pairCfg[p].divExp);
    end

    assign srcTick[p] = (pairCfg[p].src == '0) ? oscPulse : busPulse;
    assign divTick[p] = srcTick[p] && (divCnt == limit);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       divCnt <= '0;
      else if (strobes.pairRestart[p]) divCnt <= '0;
      else if (srcTick[p])             divCnt <= (divCnt == limit) ? '0 : divCnt + DIV_W'(1);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwmp_chan i_chan (
      .clk     (clk),
      .rstN    (rstN),
      .srcTick (srcTick[c/2]),
      .divTick (divTick[c/2]),
      .restart (strobes.chRestart[c]),
      .cfg     (chCfg[c]),
      .pwmOut  (pwmOut[c]),
      .pwmOe   (pwmOe[c])
    );
  end
endmodule

// File: rtl/pair_pwm.sv
module pair_pwm
  import pwmp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     oscPulse,
  input  logic                     busPulse,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdData,
  output logic [NUM_CH-1:0]        pwmOut,
  output logic [NUM_CH-1:0]        pwmOe
);
  pairCfg_t [NUM_PAIR-1:0] pairCfg;
  chCfg_t   [NUM_CH-1:0]   chCfg;
  strobe_t                 strobes;

  pwmp_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .pairCfg (pairCfg),
    .chCfg   (chCfg),
    .strobes (strobes)
  );

  pwmp_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .oscPulse (oscPulse),
    .busPulse (busPulse),
    .pairCfg  (pairCfg),
    .chCfg    (chCfg),
    .strobes  (strobes),
    .pwmOut   (pwmOut),
    .pwmOe    (pwmOe)
  );
endmodule

// File: rtl/pair_pwm_checker.sv
module pair_pwm_checker
  import pwmp_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   wrEn,
  input logic                   rdEn,
  input logic [ADDR_W-1:0]      addr,
  input logic [DATA_W-1:0]      wrData,
  input logic [DATA_W-1:0]      rdData,
  input logic [NUM_CH-1:0]      pwmOut,
  input logic [NUM_CH-1:0]      pwmOe,
  input chCfg_t [NUM_CH-1:0]    chCfg
);
  logic unusedChk;
  assign unusedChk = ^{wrData, rdData, chCfg};

  // R2: no read in the previous cycle leaves the read bus at zero
  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (rdData == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam bit [ADDR_W-1:0] CTL_A  = CH_BASE + ADDR_W'(c * CH_STRIDE);
    localparam bit [ADDR_W-1:0] TIME_A = CH_BASE + ADDR_W'(c * CH_STRIDE + TIME_OFS);

    // R2: control register readback has no bits above the polarity bit
    assert_ctl_undef_R2: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn && addr == CTL_A) |=> (rdData[DATA_W-1:POL_BIT+1] == '0));

    // R6: active count beyond the period pins the output to the active level
    assert_full_duty_R6: assert property (@(posedge clk) disable iff (!rstN)
      (chCfg[c].en && chCfg[c].act > chCfg[c].entire) |-> (pwmOut[c] == chCfg[c].pol));

    // R7: clearing the enable bit tri-states and zeroes the channel next cycle
    assert_disable_R7: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == EN_ADDR && !wrData[c]) |=> (!pwmOe[c] && !pwmOut[c]));

    // R8: a gated, enabled channel with no register write holds its output
    assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
      $past(chCfg[c].en && !chCfg[c].gate && !wrEn) |-> $stable(pwmOut[c]));

    // R9: a timing write with nonzero active count restarts in the active phase
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && addr == TIME_A && wrData[CNT_W-1:0] != '0 && chCfg[c].en)
        |=> (pwmOut[c] == $past(chCfg[c].pol)));
  end
endmodule

bind pair_pwm pair_pwm_checker i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .pwmOut (pwmOut),
  .pwmOe  (pwmOe),
  .chCfg  (chCfg)
);

// File: tb/test_pair_pwm.sv
`timescale 1ns/1ps
module test_pair_pwm;
  localparam int NC = pwmp_pkg::NUM_CH;
  localparam int NP = NC / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscPulse = 1'b1;
  logic busPulse = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NC-1:0] pwmOut, pwmOe;

  int checks = 0, errors = 0, cyc = 0, busPhase = 0;
  bit modelOn = 1'b0;

  always #2.5 clk = ~clk;

  pair_pwm i_pair_pwm (
    .clk(clk), .rstN(rstN), .oscPulse(oscPulse), .busPulse(busPulse),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pwmOut(pwmOut), .pwmOe(pwmOe));

  // bus source pulses once every three cycles
  always @(negedge clk) begin
    busPhase = (busPhase + 1) % 3;
    busPulse = (busPhase == 0);
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mSrc[NP], mExp[NP], mDiv[NP];
  int mPresc[NC], mPol[NC], mEnt[NC], mAct[NC], mPre[NC], mCnt[NC];
  bit [NC-1:0] mEn, mGate, mByp;
  logic [31:0] mRd;

  function automatic logic [31:0] mRead(input int a);
    logic [31:0] v = '0;
    for (int p = 0; p < NP; p++)
      if (a == 32 + 4*p) begin v[8:7] = 2'(mSrc[p]); v[3:0] = 4'(mExp[p]); end
    for (int c = 0; c < NC; c++) begin
      if (a == 256 + 32*c) begin v[7:0] = 8'(mPresc[c]); v[8] = mPol[c][0]; end
      if (a == 260 + 32*c) v = {16'(mEnt[c]), 16'(mAct[c])};
    end
    if (a == 64)  begin v[NC-1:0] = mGate; v[16 +: NC] = mByp; end
    if (a == 128) v[NC-1:0] = mEn;
    return v;
  endfunction

  always @(posedge clk) begin
    bit sTick[NP];
    bit dTick[NP];
    bit base;
    if (!rstN) begin
      for (int p = 0; p < NP; p++) begin mSrc[p] = 0; mExp[p] = 0; mDiv[p] = 0; end
      for (int c = 0; c < NC; c++) begin
        mPresc[c] = 0; mPol[c] = 0; mEnt[c] = 0; mAct[c] = 0; mPre[c] = 0; mCnt[c] = 0;
      end
      mEn = '0; mGate = '0; mByp = '0; mRd = '0;
    end else begin
      for (int p = 0; p < NP; p++) begin
        sTick[p] = (mSrc[p] == 0) ? oscPulse : busPulse;
        dTick[p] = sTick[p] && (mDiv[p] == (1 << mExp[p]) - 1);
      end
      for (int c = 0; c < NC; c++) begin
        base = mByp[c] ? sTick[c/2] : dTick[c/2];
        if ((wrEn && (addr == 256 + 32*c || addr == 260 + 32*c)) || !mEn[c]) begin
          mPre[c] = 0; mCnt[c] = 0;
        end else if (mGate[c] && base) begin
          if (mByp[c] || mPre[c] == mPresc[c]) begin
            mPre[c] = 0;
            mCnt[c] = (mCnt[c] >= mEnt[c]) ? 0 : mCnt[c] + 1;
          end else mPre[c]++;
        end
      end
      for (int p = 0; p < NP; p++) begin
        if (wrEn && addr == 32 + 4*p) mDiv[p] = 0;
        else if (sTick[p]) mDiv[p] = dTick[p] ? 0 : mDiv[p] + 1;
      end
      mRd = rdEn ? mRead(int'(addr)) : '0;
      if (wrEn) begin
        for (int p = 0; p < NP; p++)
          if (addr == 32 + 4*p) begin mSrc[p] = int'(wrData[8:7]); mExp[p] = int'(wrData[3:0]); end
        for (int c = 0; c < NC; c++) begin
          if (addr == 256 + 32*c) begin mPresc[c] = int'(wrData[7:0]); mPol[c] = int'(wrData[8]); end
          if (addr == 260 + 32*c) begin mEnt[c] = int'(wrData[31:16]); mAct[c] = int'(wrData[15:0]); end
        end
        if (addr == 64)  begin mGate = wrData[NC-1:0]; mByp = wrData[16 +: NC]; end
        if (addr == 128) mEn = wrData[NC-1:0];
      end
    end
  end

  // cycle-by-cycle comparison against the model (R3 R4 R5 R9 waveform)
  always @(negedge clk) begin
    if (modelOn && rstN) begin
      logic [NC-1:0] eOut, eOe;
      for (int c = 0; c < NC; c++) begin
        eOe[c]  = mEn[c];
        eOut[c] = mEn[c] && ((mCnt[c] < mAct[c]) ? mPol[c][0] : !mPol[c][0]);
      end
      chk("R5 model pwmOut", pwmOut, eOut);
      chk("R7 model pwmOe", pwmOe, eOe);
      chk("R2 model rdData", rdData, mRd);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<60000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    @(negedge clk); rdEn = 1'b0; d = rdData;
  endtask

  task automatic countHigh(input int n, output int cnt[NC]);
    for (int c = 0; c < NC; c++) cnt[c] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int c = 0; c < NC; c++) cnt[c] += int'(pwmOut[c]);
    end
  endtask

  initial begin
    logic [31:0] r;
    int cnt[NC];
    int changes;
    logic prev;

    repeat (4) @(negedge clk);
    chk("R1 reset pwmOe", pwmOe, 0);
    chk("R1 reset pwmOut", pwmOut, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset pwmOe", pwmOe, 0);
    chk("R1 after reset rdData", rdData, 0);
    modelOn = 1'b1;

    // R2 readback with undefined bits zero
    wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, r); chk("R2 pair cfg read", r, 32'h0000_018F);
    wr(12'h100, 32'hFFFF_FFFF); rd(12'h100, r); chk("R2 ctl read", r, 32'h0000_01FF);
    wr(12'h104, 32'h1234_5678); rd(12'h104, r); chk("R2 timing read", r, 32'h1234_5678);
    wr(12'h040, 32'hFFFF_FFFF); rd(12'h040, r); chk("R2 gate read", r, 32'h000F_000F);
    wr(12'h080, 32'h0000_0000); rd(12'h080, r); chk("R2 enable read", r, 0);
    rd(12'h0FC, r); chk("R2 unmapped read", r, 0);

    // base setup
    wr(12'h020, 32'h0000_0001);            // pair0: osc, M=1
    wr(12'h100, 32'h0000_0101);            // ch0: K=1, active high
    wr(12'h104, {16'd3, 16'd2});
    wr(12'h120, 32'h0000_0000);            // ch1: K=0, active low
    wr(12'h124, {16'd4, 16'd1});
    wr(12'h024, 32'h0000_0100);            // pair1: bus, M=0
    wr(12'h140, 32'h0000_0100);            // ch2: K=0, active high
    wr(12'h144, {16'd9, 16'd3});
    wr(12'h160, 32'h0000_0100);            // ch3: ACT > ENTIRE
    wr(12'h164, {16'd5, 16'd6});
    wr(12'h040, 32'h0000_000F);
    wr(12'h080, 32'h0000_000F);
    repeat (60) @(negedge clk);
    chk("R7 enabled pwmOe", pwmOe, 4'hF);
    countHigh(240, cnt);
    chk("R4 ch0 high count (M=1,K=1,ENTIRE=3,ACT=2)", cnt[0], 120);
    chk("R5 ch1 high count (active low)", cnt[1], 192);
    chk("R3 ch2 high count (bus source)", cnt[2], 72);
    chk("R6 ch3 full duty", cnt[3], 240);

    wr(12'h164, {16'd5, 16'd0});
    countHigh(60, cnt);
    chk("R6 ch3 zero duty", cnt[3], 0);

    // bypass on ch3, larger divider on pair1
    wr(12'h024, 32'h0000_0103);
    wr(12'h160, 32'h0000_0107);
    wr(12'h164, {16'd4, 16'd2});
    wr(12'h040, 32'h0008_000F);
    repeat (30) @(negedge clk);
    countHigh(240, cnt);
    chk("R8 ch3 bypass count", cnt[3], 96);
    chk("R3 ch2 divided by 2^3", cnt[2], 72);

    // gate off ch0: output frozen
    wr(12'h040, 32'h0008_000E);
    changes = 0; prev = pwmOut[0];
    repeat (50) begin
      @(negedge clk);
      if (pwmOut[0] != prev) changes++;
      prev = pwmOut[0];
    end
    chk("R8 gated ch0 output changes", changes, 0);
    chk("R8 gated ch0 still enabled", pwmOe[0], 1);

    // restart during inactive phase
    wr(12'h040, 32'h0008_000F);
    for (int i = 0; i < 40 && pwmOut[0]; i++) @(negedge clk);
    chk("R9 ch0 inactive before write", pwmOut[0], 0);
    wr(12'h104, {16'd3, 16'd2});
    chk("R9 ch0 active after restart", pwmOut[0], 1);

    // disable and re-enable ch2
    wr(12'h080, 32'h0000_000B);
    chk("R7 disabled ch2 pwmOe", pwmOe[2], 0);
    chk("R7 disabled ch2 pwmOut", pwmOut[2], 0);
    repeat (20) @(negedge clk);
    wr(12'h080, 32'h0000_000F);
    chk("R7 re-enabled ch2 starts active", pwmOut[2], 1);

    // pair1 back to the oscillator source
    wr(12'h024, 32'h0000_0000);
    repeat (20) @(negedge clk);
    countHigh(100, cnt);
    chk("R3 ch2 oscillator source", cnt[2], 30);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule